// File: doc/BRIEF.md
# Parallel Failureless Multi-Pattern Matcher

The block searches a byte stream for the fixed pattern set "AB", "ABG", "BEDE" and "EF". Every cycle it can take one beat of W bytes. Byte 0 of a beat is the earliest in the stream.

The block starts one walker at every byte offset of a window. A walker looks only for patterns that begin at its own offset. It follows the goto edges of the pattern trie from the root and stops at the first byte that has no edge. It never takes a failure jump back. Each walker may need bytes beyond the end of its window, so the block holds a beat until the next beat arrives. That beat supplies LMAX-1 lookahead bytes. As a result a window is reported one beat after it is accepted.

A pattern that crosses from one beat into the next is found by the walker at its start offset. No segment is scanned twice. At the end of a stream, a flush request evaluates the held beat with pad bytes as lookahead. The pad byte is not in the alphabet.

Top module: `pfac_matcher`

## Requirements
- R1: After reset, out_valid is 0, and out_mask is all zero whenever out_valid is 0.
- R2: The first beat after reset or after a flush produces no output. Each later beat accepted with in_valid=1 makes out_valid=1 in the next cycle, with out_win equal to the previously accepted beat.
- R3: When out_valid=1, bit p*W+i of out_mask is 1 exactly when pattern p starts at byte i of out_win. The match may use the bytes of out_win followed by the first LMAX-1 bytes of the beat that follows. Pattern ids are 0="AB", 1="ABG", 2="BEDE", 3="EF", in ASCII. Byte i sits in bits 8*i+7..8*i.
- R4: A pattern that starts near the end of a window and finishes in the following beat is flagged at its start offset in that window. A pattern that starts in the following beat is not flagged in that window.
- R5: "AB" and "ABG" at the same start offset are both flagged.
- R6: A walker stops at the first byte without a goto edge, with no failure jump. In "BEBEDE" only the walker at offset 2 reports "BEDE". In "AABG" the walker at offset 0 reports nothing.
- R7: in_eos=1 with in_valid=0 flushes the held beat: in the next cycle it is output with pad bytes 8'h00 as lookahead. After a flush no beat is held.
- R8: in_eos is ignored while in_valid=1. The cycle behaves as a plain beat and the beat stays held.
- R9: In a cycle with in_valid=0 and in_eos=0, out_valid is 0 in the next cycle and the held beat is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A beat is present on in_data |
| in_eos | input | 1 | Flush request at end of stream (honoured only when in_valid=0) |
| in_data | input | W*8 | Beat bytes, byte 0 in the low bits |
| out_valid | output | 1 | out_win and out_mask hold a result |
| out_win | output | W*8 | The window the masks refer to |
| out_mask | output | 4*W | Per-pattern start-offset masks, pattern p at bits p*W+W-1..p*W |

## Verification
The bench builds the block with W=8 and LMAX=4. At these values a 4-byte pattern can start at any of the last three offsets of a window and still complete from lookahead. Every lane therefore needs the full walk depth. A scoreboard compares every output beat against a brute-force search of the window plus its lookahead. Directed beats cover straddling patterns, shared prefixes, early stops and flush padding. A long stream of random bytes from the pattern alphabet follows, with idle gaps.

// File: rtl/pfac_pkg.sv
package pfac_pkg;
  localparam int NPAT      = 4;   // 0:AB 1:ABG 2:BEDE 3:EF
  localparam int SW        = 4;
  localparam int TRIE_LMAX = 4;

  typedef logic [SW-1:0] st_t;

  typedef struct packed {
    logic ok;
    st_t  nxt;
  } edge_t;

  // goto edges of the trie, no failure links
  function automatic edge_t goto_edge(input st_t s, input logic [7:0] b);
    edge_t e;
    e = '{ok: 1'b0, nxt: s};
    case (s)
      4'd0: begin
        if (b == 8'h41)      e = '{ok: 1'b1, nxt: 4'd1};
        else if (b == 8'h42) e = '{ok: 1'b1, nxt: 4'd4};
        else if (b == 8'h45) e = '{ok: 1'b1, nxt: 4'd8};
      end
      4'd1: if (b == 8'h42) e = '{ok: 1'b1, nxt: 4'd2};
      4'd2: if (b == 8'h47) e = '{ok: 1'b1, nxt: 4'd3};
      4'd4: if (b == 8'h45) e = '{ok: 1'b1, nxt: 4'd5};
      4'd5: if (b == 8'h44) e = '{ok: 1'b1, nxt: 4'd6};
      4'd6: if (b == 8'h45) e = '{ok: 1'b1, nxt: 4'd7};
      4'd8: if (b == 8'h46) e = '{ok: 1'b1, nxt: 4'd9};
      default: e = '{ok: 1'b0, nxt: s};
    endcase
    return e;
  endfunction

  function automatic logic [NPAT-1:0] accept_vec(input st_t s);
    case (s)
      4'd2:    return 4'b0001;
      4'd3:    return 4'b0010;
      4'd7:    return 4'b0100;
      4'd9:    return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/pfac_lane.sv
module pfac_lane
  import pfac_pkg::*;
#(
  parameter int LMAX = TRIE_LMAX
) (
  input  logic [LMAX*8-1:0] bytes_in,
  output logic [NPAT-1:0]   hits
);
  st_t   st;
  logic  live;
  edge_t e;

  always_comb begin
    st   = '0;
    live = 1'b1;
    hits = '0;
    e    = '{ok: 1'b0, nxt: '0};
    for (int j = 0; j < LMAX; j++) begin
      if (live) begin
        e = goto_edge(st, bytes_in[8*j +: 8]);
        if (e.ok) begin
          st   = e.nxt;
          hits = hits | accept_vec(st);
        end else begin
          live = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pfac_window.sv
module pfac_window #(
  parameter int         W    = 8,
  parameter int         LMAX = 4,
  parameter logic [7:0] PAD  = 8'h00,
  localparam int        LA   = LMAX - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_eos,
  input  logic [W*8-1:0]        in_data,
  output logic [(W+LA)*8-1:0]   win_ext,
  output logic                  eval_en
);
  logic [W*8-1:0] hold_q, hold_d;
  logic           hold_v_q, hold_v_d;
  logic           flush;
  logic [LA*8-1:0] look;

  assign flush = in_eos & ~in_valid;

  always_comb begin
    hold_d   = hold_q;
    hold_v_d = hold_v_q;
    if (in_valid) begin
      hold_d   = in_data;
      hold_v_d = 1'b1;
    end else if (flush) begin
      hold_v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      hold_v_q <= 1'b0;
    end else begin
      hold_v_q <= hold_v_d;
      if (in_valid) hold_q <= hold_d;
    end
  end

  always_comb begin
    look = {LA{PAD}};
    if (in_valid) look = in_data[LA*8-1:0];
  end

  assign win_ext = {look, hold_q};
  assign eval_en = hold_v_q & (in_valid | in_eos);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (in_eos && !in_valid) |=> !hold_v_q);
  a_r8_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> hold_v_q);
  a_r9_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !in_eos) |=> ($stable(hold_v_q) && $stable(hold_q)));
endmodule

// File: rtl/pfac_matcher.sv
module pfac_matcher
  import pfac_pkg::*;
#(
  parameter int         W    = 8,
  parameter int         LMAX = TRIE_LMAX,
  parameter logic [7:0] PAD  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_eos,
  input  logic [W*8-1:0]    in_data,
  output logic              out_valid,
  output logic [W*8-1:0]    out_win,
  output logic [NPAT*W-1:0] out_mask
);
  localparam int LA = LMAX - 1;

  logic [1:0] rst_ff;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_q = rst_ff[1];

  logic [(W+LA)*8-1:0] ext;
  logic                eval_en;

  pfac_window #(.W(W), .LMAX(LMAX), .PAD(PAD)) u_win (
    .clk(clk), .rst_n(rst_q), .in_valid(in_valid), .in_eos(in_eos),
    .in_data(in_data), .win_ext(ext), .eval_en(eval_en)
  );

  logic [NPAT-1:0] lane_hits [W];

  for (genvar i = 0; i < W; i++) begin : g_lane
    pfac_lane #(.LMAX(LMAX)) u_lane (
      .bytes_in(ext[8*i +: 8*LMAX]),
      .hits(lane_hits[i])
    );
  end

  logic [NPAT*W-1:0] mask_d;
  always_comb begin
    for (int p = 0; p < NPAT; p++)
      for (int i = 0; i < W; i++)
        mask_d[p*W+i] = eval_en & lane_hits[i][p];
  end

  logic              valid_q;
  logic [W*8-1:0]    win_q;
  logic [NPAT*W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      valid_q <= 1'b0;
      win_q   <= '0;
      mask_q  <= '0;
    end else begin
      valid_q <= eval_en;
      mask_q  <= mask_d;
      if (eval_en) win_q <= ext[W*8-1:0];
    end
  end

  assign out_valid = valid_q;
  assign out_win   = win_q;
  assign out_mask  = mask_q;

  a_r1_quiet_mask: assert property (@(posedge clk) disable iff (!rst_q)
    !out_valid |-> (out_mask == '0));
  a_r9_idle_no_out: assert property (@(posedge clk) disable iff (!rst_q)
    (!in_valid && !in_eos) |=> !out_valid);

  for (genvar i = 0; i < W; i++) begin : g_chk
    a_r5_abg_has_ab: assert property (@(posedge clk) disable iff (!rst_q)
      out_mask[W+i] |-> out_mask[i]);
    a_r3_ab_byte: assert property (@(posedge clk) disable iff (!rst_q)
      out_mask[i] |-> (out_win[8*i +: 8] == 8'h41));
    a_r3_bede_byte: assert property (@(posedge clk) disable iff (!rst_q)
      out_mask[2*W+i] |-> (out_win[8*i +: 8] == 8'h42));
    a_r3_ef_byte: assert property (@(posedge clk) disable iff (!rst_q)
      out_mask[3*W+i] |-> (out_win[8*i +: 8] == 8'h45));
  end
endmodule

// File: tb/pfac_matcher_tb.sv
module pfac_matcher_tb;
  localparam int W  = 8;
  localparam int LM = 4;
  localparam int LA = LM - 1;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_eos = 1'b0;
  logic [W*8-1:0] in_data = '0;
  logic out_valid;
  logic [W*8-1:0] out_win;
  logic [NP*W-1:0] out_mask;

  always #5 clk = ~clk;

  pfac_matcher #(.W(W), .LMAX(LM), .PAD(8'h00)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eos(in_eos),
    .in_data(in_data), .out_valid(out_valid), .out_win(out_win),
    .out_mask(out_mask)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic              exp_v_q[$];
  logic [W*8-1:0]    exp_win_q[$];
  logic [NP*W-1:0]   exp_mask_q[$];
  string             exp_tag_q[$];

  logic [W*8-1:0] held;
  logic           held_v = 1'b0;

  string pats[NP] = '{"AB", "ABG", "BEDE", "EF"};

  function automatic logic [NP*W-1:0] ref_mask(input logic [(W+LA)*8-1:0] ext);
    logic [NP*W-1:0] m;
    logic hit;
    m = '0;
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < W; i++) begin
        hit = 1'b1;
        for (int k = 0; k < pats[p].len(); k++)
          if (ext[8*(i+k) +: 8] != pats[p][k]) hit = 1'b0;
        m[p*W+i] = hit;
      end
    return m;
  endfunction

  function automatic logic [W*8-1:0] s2b(input string s);
    logic [W*8-1:0] r;
    for (int k = 0; k < W; k++) r[8*k +: 8] = s[k];
    return r;
  endfunction

  task automatic drive(input logic v, input logic eos, input logic [W*8-1:0] d,
                       input string tag);
    logic [(W+LA)*8-1:0] ext;
    @(negedge clk);
    in_valid = v;
    in_eos   = eos;
    in_data  = d;
    if ((v || eos) && held_v) begin
      ext = v ? {d[LA*8-1:0], held} : {{LA{8'h00}}, held};
      exp_v_q.push_back(1'b1);
      exp_win_q.push_back(held);
      exp_mask_q.push_back(ref_mask(ext));
    end else begin
      exp_v_q.push_back(1'b0);
      exp_win_q.push_back('0);
      exp_mask_q.push_back('0);
    end
    exp_tag_q.push_back(tag);
    if (v) begin
      held   = d;
      held_v = 1'b1;
    end else if (eos) begin
      held_v = 1'b0;
    end
  endtask

  task automatic beat_s(input string s, input string tag);
    drive(1'b1, 1'b0, s2b(s), tag);
  endtask

  // monitor: one expected item per driven cycle, compared after the edge
  initial begin
    logic ev;
    logic [W*8-1:0] ew;
    logic [NP*W-1:0] em;
    string et;
    forever begin
      @(posedge clk);
      #3;
      if (exp_v_q.size() > 0) begin
        ev = exp_v_q.pop_front();
        ew = exp_win_q.pop_front();
        em = exp_mask_q.pop_front();
        et = exp_tag_q.pop_front();
        checks++;
        if (out_valid !== ev) begin
          fails++;
          $display("FAIL %s: out_valid actual %0b expected %0b", et, out_valid, ev);
        end else if (ev && out_win !== ew) begin
          fails++;
          $display("FAIL %s: out_win actual %h expected %h", et, out_win, ew);
        end else if (out_mask !== em) begin
          fails++;
          $display("FAIL %s: out_mask actual %h expected %h", et, out_mask, em);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_mask !== '0) begin
      fails++;
      $display("FAIL R1: reset out_valid %0b mask %h expected 0 and 0", out_valid, out_mask);
    end

    beat_s("ABEDEXXX", "R2 first beat silent");
    beat_s("XXXXXXAB", "R6 ABEDE early stop");
    beat_s("GXXXXXXE", "R5 AB and ABG same offset");
    beat_s("FBEDEXXX", "R4 EF straddles");
    beat_s("XXXXXBED", "R4 no flag from lookahead start");
    beat_s("EAABGXXX", "R4 BEDE straddles");
    beat_s("BEBEDEEF", "R6 AABG no failure jump");
    drive(1'b0, 1'b0, '0, "R9 idle no output");
    drive(1'b0, 1'b0, '0, "R9 idle keeps beat");
    drive(1'b1, 1'b1, s2b("XXXXXABE"), "R8 eos ignored BEBEDE");
    drive(1'b0, 1'b1, '0, "R7 flush pads tail");
    beat_s("EFXXXXXX", "R7 nothing held after flush");
    beat_s("ABABABAB", "R2 output after refill");
    drive(1'b0, 1'b1, '0, "R7 flush repeated AB");
    drive(1'b0, 1'b1, '0, "R7 flush with nothing held");
    drive(1'b0, 1'b0, '0, "R9 idle");

    for (int n = 0; n < 400; n++) begin
      logic [W*8-1:0] d;
      string alpha;
      alpha = "ABDEFGX";
      for (int k = 0; k < W; k++) d[8*k +: 8] = alpha[$urandom_range(0, 6)];
      if ($urandom_range(0, 7) == 0) drive(1'b0, 1'b0, '0, "R9 random idle");
      drive(1'b1, 1'b0, d, "R3 random stream");
    end
    drive(1'b0, 1'b1, '0, "R7 random flush");
    repeat (4) drive(1'b0, 1'b0, '0, "R9 drain");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_v_q.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d results outstanding, expected 0", exp_v_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule